// File: doc/BRIEF.md
# Sleep Mode Controller

This block manages low-power states for a small processor core. Software programs an 8-bit control register over a simple register bus. The register holds a 3-bit mode code and a sleep-enable bit. When the core executes its sleep instruction, it sends a one-cycle pulse. If the enable bit is set and the mode code is legal, the controller latches the mode and halts the CPU. It then drops the clock enables that the chosen mode switches off.

An enabled interrupt or a reset request ends the sleep. The controller turns the clocks back on at once. It keeps the CPU halted through a per-mode start-up delay plus four further cycles, then releases it. The deepest mode, power-off, has two extra rules. It is armed only through a short window: once written, the register clears itself four cycles later. Leaving power-off always asks the system for a full reset instead of resuming where execution stopped.

Top module: `sleep_ctl`

## Requirements
- R1: After reset the register reads 0x00, `sleeping`, `cpuHalt` and `resetReq` are low, and all four clock enables are high.
- R2: The register keeps bit 0 as sleep enable and bits 3:1 as the mode code. Bits 7:4 read as zero whatever is written.
- R3: A sleep pulse has no effect when the enable bit is 0, or when the mode code is a reserved value (5, 6 or 7). The core stays awake with all clocks enabled.
- R4: A sleep pulse with the enable bit set and a legal mode raises `sleeping` and `cpuHalt` from the next cycle. `activeMode` then shows the latched mode code (0 idle, 1 ADC noise reduction, 2 power-down, 3 power-save, 4 power-off).
- R5: While asleep, the clock enables depend on the mode. Idle drops only the CPU clock. ADC noise reduction drops the CPU and I/O clocks. Power-save keeps only the asynchronous timer clock. Power-down and power-off drop all four clocks.
- R6: Writing mode 4 with the enable bit set clears the whole register at the fourth clock edge after the write. A sleep pulse sampled at any of those four edges enters power-off; a pulse one edge later does nothing. Writes of any other value do not self-clear.
- R7: After a wake event, `cpuHalt` stays high for S+4 cycles and then falls together with `sleeping`. With default parameters, S is 0 for idle, 2 for ADC noise reduction, 6 for power-save, 8 for power-down and 10 for power-off.
- R8: A wake caused by the reset input ends with a one-cycle `resetReq` pulse in the first cycle after `cpuHalt` falls. An interrupt wake from a mode other than power-off gives no pulse.
- R9: Any wake from power-off ends with that same one-cycle `resetReq` pulse.
- R10: While `sleeping` is high, register writes are ignored and `activeMode` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| sleepPulse | input | 1 | One-cycle pulse from the sleep instruction |
| irqWake | input | 1 | Enabled interrupt pending |
| rstWake | input | 1 | Reset event that wakes the core to the reset vector |
| sleeping | output | 1 | High from sleep entry until the CPU resumes |
| activeMode | output | 3 | Mode latched at entry |
| cpuHalt | output | 1 | CPU halt |
| clkEnCpu | output | 1 | CPU clock enable |
| clkEnIo | output | 1 | I/O clock enable |
| clkEnAdc | output | 1 | ADC clock enable |
| clkEnAsync | output | 1 | Asynchronous timer clock enable |
| resetReq | output | 1 | One-cycle full reset request |

## Verification
Some rules are checked by the assertions on every cycle. These are the entry rule and the disabled-pulse rule, the nesting of clock gating by depth, and the stability of the latched mode and register while asleep. They also cover the rule that the enable bit drops without a write only when power-off was set, and that `resetReq` appears only right after a halt ends. Other behaviour can only be shown by the bench scenarios. These are the exact edge at which the power-off arm window closes, and the length of each mode's halt. They also include the mode-specific clock pattern, and which wake causes lead to a reset request.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  localparam logic [2:0] MODE_IDLE  = 3'd0;
  localparam logic [2:0] MODE_ADCNR = 3'd1;
  localparam logic [2:0] MODE_PDOWN = 3'd2;
  localparam logic [2:0] MODE_PSAVE = 3'd3;
  localparam logic [2:0] MODE_POFF  = 3'd4;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } sleepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enter;  // latch the mode code
    logic wake;   // load the halt counter
    logic lock;   // block register writes
  } ctlStrobe_t;

  function automatic logic modeLegal(input logic [2:0] m);
    return m <= MODE_POFF;
  endfunction

endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int ARM_CYCLES  = 4,
  parameter int HALT_EXTRA  = 4,
  parameter int START_ADCNR = 2,
  parameter int START_PSAVE = 6,
  parameter int START_PDOWN = 8,
  parameter int START_POFF  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [3:0] regWrLow,
  input  ctlStrobe_t strobe,
  output logic [7:0] regRdData,
  output logic       ctlEn,
  output logic [2:0] ctlMode,
  output logic [2:0] heldMode,
  output logic       wakeLast
);

  localparam int MAX_AB    = (START_ADCNR > START_PSAVE) ? START_ADCNR : START_PSAVE;
  localparam int MAX_CD    = (START_PDOWN > START_POFF) ? START_PDOWN : START_POFF;
  localparam int MAX_START = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int WAKE_W    = $clog2(MAX_START + HALT_EXTRA + 1);
  localparam int ARM_W     = $clog2(ARM_CYCLES + 1);

  logic [ARM_W-1:0]  armCnt;
  logic [WAKE_W-1:0] wakeCnt;
  logic [WAKE_W-1:0] wakeLoad;
  logic              wrOk;
  logic              armLoad;

  assign wrOk    = regWrEn && !strobe.lock;
  assign armLoad = (regWrLow[3:1] == MODE_POFF) && regWrLow[0];

  // control register with self-clearing arm window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlMode <= MODE_IDLE;
      ctlEn   <= 1'b0;
      armCnt  <= '0;
    end else if (wrOk) begin
      ctlMode <= regWrLow[3:1];
      ctlEn   <= regWrLow[0];
      armCnt  <= armLoad ? ARM_W'(ARM_CYCLES) : '0;
    end else if (armCnt != '0) begin
      armCnt <= armCnt - 1'b1;
      if (armCnt == ARM_W'(1)) begin
        ctlMode <= MODE_IDLE;
        ctlEn   <= 1'b0;
      end
    end
  end

  assign regRdData = {4'b0000, ctlMode, ctlEn};

  // mode latched at entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldMode <= MODE_IDLE;
    else if (strobe.enter) heldMode <= ctlMode;
  end

  always_comb begin
    case (heldMode)
      MODE_ADCNR: wakeLoad = WAKE_W'(START_ADCNR + HALT_EXTRA);
      MODE_PSAVE: wakeLoad = WAKE_W'(START_PSAVE + HALT_EXTRA);
      MODE_PDOWN: wakeLoad = WAKE_W'(START_PDOWN + HALT_EXTRA);
      MODE_POFF:  wakeLoad = WAKE_W'(START_POFF + HALT_EXTRA);
      default:    wakeLoad = WAKE_W'(HALT_EXTRA);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wakeCnt <= '0;
    else if (strobe.wake)     wakeCnt <= wakeLoad;
    else if (wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
  end

  assign wakeLast = (wakeCnt == WAKE_W'(1));

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int NUM_CLK = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepPulse,
  input  logic               irqWake,
  input  logic               rstWake,
  input  logic               ctlEn,
  input  logic [2:0]         ctlMode,
  input  logic [2:0]         heldMode,
  input  logic               wakeLast,
  output ctlStrobe_t         strobe,
  output logic               sleeping,
  output logic               cpuHalt,
  output logic               resetReq,
  output logic [NUM_CLK-1:0] clkEn
);

  sleepState_t state;
  logic        rstCause;
  logic [2:0]  depth;
  logic [2:0]  gateDepth;

  always_comb begin
    strobe.enter = (state == ST_RUN) && sleepPulse && ctlEn && modeLegal(ctlMode);
    strobe.wake  = (state == ST_SLEEP) && (irqWake || rstWake);
    strobe.lock  = (state != ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      rstCause <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= (state == ST_WAKE) && wakeLast &&
                  (rstCause || heldMode == MODE_POFF);
      case (state)
        ST_RUN:   if (strobe.enter) state <= ST_SLEEP;
        ST_SLEEP: if (strobe.wake) begin
                    state    <= ST_WAKE;
                    rstCause <= rstWake;
                  end
        ST_WAKE:  if (wakeLast) state <= ST_RUN;
        default:  state <= ST_RUN;
      endcase
    end
  end

  assign sleeping = (state != ST_RUN);
  assign cpuHalt  = (state != ST_RUN);

  // gating depth: clock i stops when depth exceeds i
  always_comb begin
    case (heldMode)
      MODE_IDLE:  depth = 3'd1;
      MODE_ADCNR: depth = 3'd2;
      MODE_PSAVE: depth = 3'd3;
      default:    depth = 3'd4;
    endcase
    gateDepth = (state == ST_SLEEP) ? depth : 3'd0;
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
    assign clkEn[i] = !(gateDepth > 3'(i));
  end

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_pkg::*;
#(
  parameter int ARM_CYCLES  = 4,
  parameter int HALT_EXTRA  = 4,
  parameter int START_ADCNR = 2,
  parameter int START_PSAVE = 6,
  parameter int START_PDOWN = 8,
  parameter int START_POFF  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sleepPulse,
  input  logic       irqWake,
  input  logic       rstWake,
  output logic       sleeping,
  output logic [2:0] activeMode,
  output logic       cpuHalt,
  output logic       clkEnCpu,
  output logic       clkEnIo,
  output logic       clkEnAdc,
  output logic       clkEnAsync,
  output logic       resetReq
);

  localparam int NUM_CLK = 4;

  ctlStrobe_t         strobe;
  logic               ctlEn;
  logic [2:0]         ctlMode;
  logic [2:0]         heldMode;
  logic               wakeLast;
  logic [NUM_CLK-1:0] clkEn;
  logic [3:0]         unusedHi;

  assign unusedHi = regWrData[7:4];

  sleep_dp #(
    .ARM_CYCLES (ARM_CYCLES),
    .HALT_EXTRA (HALT_EXTRA),
    .START_ADCNR(START_ADCNR),
    .START_PSAVE(START_PSAVE),
    .START_PDOWN(START_PDOWN),
    .START_POFF (START_POFF)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrLow (regWrData[3:0]),
    .strobe   (strobe),
    .regRdData(regRdData),
    .ctlEn    (ctlEn),
    .ctlMode  (ctlMode),
    .heldMode (heldMode),
    .wakeLast (wakeLast)
  );

  sleep_fsm #(.NUM_CLK(NUM_CLK)) fsm_i (
    .clk       (clk),
    .rstN      (rstN),
    .sleepPulse(sleepPulse),
    .irqWake   (irqWake),
    .rstWake   (rstWake),
    .ctlEn     (ctlEn),
    .ctlMode   (ctlMode),
    .heldMode  (heldMode),
    .wakeLast  (wakeLast),
    .strobe    (strobe),
    .sleeping  (sleeping),
    .cpuHalt   (cpuHalt),
    .resetReq  (resetReq),
    .clkEn     (clkEn)
  );

  assign activeMode = heldMode;
  assign clkEnCpu   = clkEn[0];
  assign clkEnIo    = clkEn[1];
  assign clkEnAdc   = clkEn[2];
  assign clkEnAsync = clkEn[3];

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       sleepPulse,
  input logic       irqWake,
  input logic       rstWake,
  input logic       sleeping,
  input logic [2:0] activeMode,
  input logic       cpuHalt,
  input logic       clkEnCpu,
  input logic       clkEnIo,
  input logic       clkEnAdc,
  input logic       clkEnAsync,
  input logic       resetReq
);

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepPulse && regRdData[0] && regRdData[3:1] <= 3'd4)
      |=> (sleeping && cpuHalt));

  // R3
  no_entry_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepPulse && !regRdData[0]) |=> !sleeping);

  // R3
  no_entry_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepPulse && regRdData[3:1] > 3'd4) |=> !sleeping);

  // R5
  gate_nesting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnAdc) |-> (!clkEnIo && !clkEnCpu && cpuHalt));

  // R5
  gate_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnIo) |-> !clkEnCpu);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |=> (!sleeping || $stable(activeMode)));

  // R10
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && regWrEn && regRdData[3:1] != 3'd4) |=> $stable(regRdData));

  // R6
  self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regRdData[0]) && !$past(regWrEn)) |-> ($past(regRdData[3:1]) == 3'd4));

  // R8
  reset_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(cpuHalt) && !cpuHalt));

  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> !sleeping);

endmodule

bind sleep_ctl sleep_ctl_chk chk_i (.*);

// File: tb/sleep_ctl_tb_top.sv
module sleep_ctl_tb_top;

  localparam int HALF = 2;
  localparam int SEL_RD = 0, SEL_SLP = 1, SEL_MODE = 2, SEL_CLK = 3, SEL_HALT = 4, SEL_RST = 5;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] val;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sleepPulse = 1'b0;
  logic       irqWake = 1'b0;
  logic       rstWake = 1'b0;
  logic       sleeping;
  logic [2:0] activeMode;
  logic       cpuHalt;
  logic       clkEnCpu, clkEnIo, clkEnAdc, clkEnAsync;
  logic       resetReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #HALF clk = ~clk;

  sleep_ctl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sleepPulse(sleepPulse), .irqWake(irqWake),
    .rstWake(rstWake), .sleeping(sleeping), .activeMode(activeMode),
    .cpuHalt(cpuHalt), .clkEnCpu(clkEnCpu), .clkEnIo(clkEnIo),
    .clkEnAdc(clkEnAdc), .clkEnAsync(clkEnAsync), .resetReq(resetReq)
  );

  function automatic logic [7:0] sigVal(input int sel);
    case (sel)
      SEL_RD:   return regRdData;
      SEL_SLP:  return {7'd0, sleeping};
      SEL_MODE: return {5'd0, activeMode};
      SEL_CLK:  return {4'd0, clkEnCpu, clkEnIo, clkEnAdc, clkEnAsync};
      SEL_HALT: return {7'd0, cpuHalt};
      default:  return {7'd0, resetReq};
    endcase
  endfunction

  // monitor: pops expectations and compares just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        act = sigVal(it.sel);
        checks++;
        if (act !== it.val) begin
          failures++;
          $display("FAIL %s sel=%0d actual=0x%02h expected=0x%02h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic expectSig(input string req, input int sel, input logic [7:0] v);
    expQ.push_back('{req: req, sel: sel, val: v});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseSleep();
    sleepPulse = 1'b1;
    @(negedge clk);
    sleepPulse = 1'b0;
  endtask

  task automatic pulseIrq();
    irqWake = 1'b1;
    @(negedge clk);
    irqWake = 1'b0;
  endtask

  task automatic pulseRst();
    rstWake = 1'b1;
    @(negedge clk);
    rstWake = 1'b0;
  endtask

  // enter a mode, check clocks, wake, then check halt length and reset request
  task automatic sleepCycle(input logic [7:0] wr, input logic [3:0] clkPat,
                            input int halt, input bit byRst, input bit expRst);
    wrReg(wr);
    pulseSleep();
    expectSig("R4", SEL_SLP, 8'd1);
    expectSig("R4", SEL_HALT, 8'd1);
    expectSig("R4", SEL_MODE, {5'd0, wr[3:1]});
    expectSig("R5", SEL_CLK, {4'd0, clkPat});
    tick(2);
    if (byRst) pulseRst(); else pulseIrq();
    expectSig("R7", SEL_CLK, 8'h0F);
    tick(halt - 1);
    expectSig("R7", SEL_HALT, 8'd1);
    expectSig("R7", SEL_SLP, 8'd1);
    tick(1);
    expectSig("R7", SEL_HALT, 8'd0);
    expectSig("R7", SEL_SLP, 8'd0);
    expectSig(expRst ? "R9" : "R8", SEL_RST, {7'd0, expRst});
    tick(1);
    expectSig("R8", SEL_RST, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    expectSig("R1", SEL_RD, 8'h00);
    expectSig("R1", SEL_SLP, 8'd0);
    expectSig("R1", SEL_HALT, 8'd0);
    expectSig("R1", SEL_CLK, 8'h0F);
    expectSig("R1", SEL_RST, 8'd0);
    tick(1);

    // R2: reserved upper bits read zero
    wrReg(8'hF5);
    expectSig("R2", SEL_RD, 8'h05);
    tick(6);
    expectSig("R6", SEL_RD, 8'h05);

    // R3: disabled pulse and reserved codes
    wrReg(8'h04);
    pulseSleep();
    expectSig("R3", SEL_SLP, 8'd0);
    expectSig("R3", SEL_CLK, 8'h0F);
    wrReg(8'h0B);
    pulseSleep();
    expectSig("R3", SEL_SLP, 8'd0);
    expectSig("R3", SEL_HALT, 8'd0);
    wrReg(8'h0F);
    pulseSleep();
    expectSig("R3", SEL_SLP, 8'd0);

    // R10: write ignored while asleep in idle
    wrReg(8'h01);
    pulseSleep();
    expectSig("R5", SEL_CLK, 8'h07);
    wrReg(8'h07);
    expectSig("R10", SEL_RD, 8'h01);
    expectSig("R10", SEL_MODE, 8'd0);
    pulseIrq();
    tick(3);
    expectSig("R7", SEL_HALT, 8'd1);
    tick(1);
    expectSig("R7", SEL_HALT, 8'd0);
    expectSig("R8", SEL_RST, 8'd0);
    tick(1);

    // each mode: write, clock pattern {cpu,io,adc,async}, halt, cause, reset expected
    sleepCycle(8'h01, 4'b0111, 4,  1'b0, 1'b0);
    sleepCycle(8'h03, 4'b0011, 6,  1'b0, 1'b0);
    sleepCycle(8'h07, 4'b0001, 10, 1'b1, 1'b1);
    sleepCycle(8'h05, 4'b0000, 12, 1'b0, 1'b0);

    // R6: power-off self clear after four edges
    wrReg(8'h09);
    expectSig("R6", SEL_RD, 8'h09);
    tick(3);
    expectSig("R6", SEL_RD, 8'h09);
    tick(1);
    expectSig("R6", SEL_RD, 8'h00);

    // R6: pulse one edge late does nothing
    wrReg(8'h09);
    tick(4);
    pulseSleep();
    expectSig("R6", SEL_SLP, 8'd0);
    expectSig("R6", SEL_CLK, 8'h0F);

    // R6: pulse on the last edge of the window enters power-off
    wrReg(8'h09);
    tick(3);
    pulseSleep();
    expectSig("R6", SEL_SLP, 8'd1);
    expectSig("R6", SEL_MODE, 8'd4);
    expectSig("R5", SEL_CLK, 8'h00);
    tick(2);
    pulseIrq();
    tick(13);
    expectSig("R7", SEL_HALT, 8'd1);
    tick(1);
    expectSig("R7", SEL_HALT, 8'd0);
    expectSig("R9", SEL_RST, 8'd1);
    tick(1);
    expectSig("R9", SEL_RST, 8'd0);

    // R6: pulse on the first edge of the window, full sequence
    wrReg(8'h09);
    pulseSleep();
    expectSig("R6", SEL_SLP, 8'd1);
    expectSig("R6", SEL_MODE, 8'd4);
    tick(2);
    pulseRst();
    tick(13);
    expectSig("R7", SEL_HALT, 8'd1);
    tick(1);
    expectSig("R9", SEL_RST, 8'd1);

    tick(3);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule